// File: doc/BRIEF.md
# Three-Rail Power Sequencer with Hands-Free Power Window

This block is the digital power-on/off controller for a small power-management unit. It drives the enable inputs of three regulators: a core buck converter and two linear regulators (LDO1 and LDO2). The system can be brought up in two ways. A level power-enable input keeps the rails on for as long as it is high. A rising edge on the hands-free trigger opens a temporary power window of fixed length. During that window the processor boots and is expected to raise the power-enable input to keep the supply alive. If it does not, the rails shut down when the window closes.

On power-up the buck comes on first and LDO1 follows after a fixed delay. LDO2 comes on a fixed delay after LDO1 reports power-good, and only if its active-low enable input asks for it. On power-down LDO1 drops first, LDO2 drops on the next cycle, and the buck drops last after its own delay. Sequencing waits for the undervoltage-OK flag. If that flag is lost, every enable is cut at once without any sequencing. All delays are parameters given in clock cycles. The power-enable, hands-free and LDO2-enable inputs each pass through a two-flop synchronizer.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, all three enables (buck, LDO1, LDO2) are low.
- R2: No rail enables while uv_ok_i is low. If uv_ok_i is low at a clock edge, all three enables are low after that edge, whatever the sequencing state. If uv_ok_i rises while power is requested, the buck enables on the first edge.
- R3: When pwr_en_i rises from the off state, buck_en_o rises on the third clock edge after the change, because of the two-flop synchronizer plus one register.
- R4: ldo1_en_o rises exactly LDO1_DLY clock edges after buck_en_o rises.
- R5: LDO2 turns on LDO2_DLY edges after the edge at which ldo1_pg_i is first sampled high with LDO1 on, and only if ldo2_off_i is low (low means on). Once the ramp has completed, ldo2_en_o follows the inverse of ldo2_off_i with a latency of three edges. No rail moves while power-good is still low.
- R6: On removal of the power request, ldo1_en_o falls first, ldo2_en_o falls one edge later, and buck_en_o falls BUCK_OFF_DLY edges after ldo1_en_o. For pwr_en_i this first edge is the third edge after the input falls.
- R7: A low-to-high transition of hf_trig_i while power is off opens a window. buck_en_o rises on the fourth edge after the transition. The power request ends after HF_WIN cycles, and ldo1_en_o falls on edge 4+HF_WIN after the transition.
- R8: Keeping hf_trig_i high after the window has closed does not reopen it. Only a new low-to-high transition does.
- R9: While the synchronized pwr_en_i is high, hf_trig_i transitions open no window, so later removal of pwr_en_i shuts the rails down at once.
- R10: If pwr_en_i rises during an open window, the rails stay on after the window's end for as long as pwr_en_i stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en_i | input | 1 | Level power request (asynchronous) |
| hf_trig_i | input | 1 | Hands-free trigger; rising edge opens the power window (asynchronous) |
| ldo2_off_i | input | 1 | LDO2 enable request, active low (asynchronous) |
| uv_ok_i | input | 1 | Supply above undervoltage threshold (synchronous to clk) |
| ldo1_pg_i | input | 1 | LDO1 power-good (synchronous to clk) |
| buck_en_o | output | 1 | Buck converter enable |
| ldo1_en_o | output | 1 | LDO1 enable |
| ldo2_en_o | output | 1 | LDO2 enable |

## Verification
The latencies are fixed. A synchronized input changes an enable on the third edge after it moves. A hands-free transition reaches the buck on the fourth edge, because of the extra edge-detect flop. uv_ok_i and ldo1_pg_i act on the very next edge. The bench queues every expected enable pattern against an absolute cycle number, worked out from these latencies and the delay parameters. It checks the last cycle before each transition as well as the cycle of the transition itself, so a shift by one cycle in any delay is caught. Sampling happens one nanosecond after the rising edge, and inputs change on the falling edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF       = 3'd0,
        SQ_BUCK_WAIT = 3'd1,
        SQ_PG_WAIT   = 3'd2,
        SQ_L2_WAIT   = 3'd3,
        SQ_ON        = 3'd4,
        SQ_DROP_L2   = 3'd5,
        SQ_DROP_BUCK = 3'd6
    } seq_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] stage_d;
            if (s == 0) begin : g_first
                always_comb stage_d = async_i;
            end else begin : g_next
                always_comb stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_hf_window.sv
module pwr_hf_window #(
    parameter int unsigned HF_WIN = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hf_s_i,
    input  logic pwr_en_s_i,
    output logic win_open_o
);
    localparam int CW = $clog2(HF_WIN + 1);

    typedef struct packed {
        logic          hf_prev;
        logic [CW-1:0] cnt;
    } win_t;

    win_t cur_q, nxt_d;
    logic rise;

    assign rise = hf_s_i && !cur_q.hf_prev;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.hf_prev = hf_s_i;
        if (pwr_en_s_i)             nxt_d.cnt = '0;
        else if (rise)              nxt_d.cnt = CW'(HF_WIN);
        else if (cur_q.cnt != '0)   nxt_d.cnt = cur_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign win_open_o = (cur_q.cnt != '0);

    AST_WIN_OPENS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open_o) |-> $past(rise)); // R7
    AST_WIN_SHUT_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en_s_i |=> !win_open_o); // R9
endmodule

// File: rtl/pwr_rail_fsm.sv
module pwr_rail_fsm
    import pwr_seq_pkg::*;
#(
    parameter int unsigned LDO1_DLY     = 10,
    parameter int unsigned LDO2_DLY     = 8,
    parameter int unsigned BUCK_OFF_DLY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req_i,
    input  logic uv_ok_i,
    input  logic ldo1_pg_i,
    input  logic ldo2_want_i,
    output logic buck_o,
    output logic ldo1_o,
    output logic ldo2_o
);
    localparam int unsigned CMAX = max3(LDO1_DLY, LDO2_DLY, BUCK_OFF_DLY);
    localparam int CW = $clog2(CMAX + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          buck;
        logic          ldo1;
        logic          ldo2;
    } rail_t;

    rail_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!uv_ok_i) begin
            nxt_d = '{st: SQ_OFF, cnt: '0, buck: 1'b0, ldo1: 1'b0, ldo2: 1'b0};
        end else begin
            unique case (cur_q.st)
                SQ_OFF: begin
                    if (on_req_i) begin
                        nxt_d.st   = SQ_BUCK_WAIT;
                        nxt_d.buck = 1'b1;
                        nxt_d.cnt  = CW'(LDO1_DLY - 1);
                    end
                end
                SQ_DROP_L2: begin
                    nxt_d.ldo2 = 1'b0;
                    nxt_d.cnt  = cur_q.cnt - 1'b1;
                    nxt_d.st   = SQ_DROP_BUCK;
                end
                SQ_DROP_BUCK: begin
                    if (cur_q.cnt == '0) begin
                        nxt_d.buck = 1'b0;
                        nxt_d.st   = SQ_OFF;
                    end else begin
                        nxt_d.cnt = cur_q.cnt - 1'b1;
                    end
                end
                default: begin
                    if (!on_req_i) begin
                        nxt_d.ldo1 = 1'b0;
                        nxt_d.st   = SQ_DROP_L2;
                        nxt_d.cnt  = CW'(BUCK_OFF_DLY - 1);
                    end else begin
                        case (cur_q.st)
                            SQ_BUCK_WAIT: begin
                                if (cur_q.cnt == '0) begin
                                    nxt_d.ldo1 = 1'b1;
                                    nxt_d.st   = SQ_PG_WAIT;
                                end else begin
                                    nxt_d.cnt = cur_q.cnt - 1'b1;
                                end
                            end
                            SQ_PG_WAIT: begin
                                if (ldo1_pg_i) begin
                                    nxt_d.st  = SQ_L2_WAIT;
                                    nxt_d.cnt = CW'(LDO2_DLY - 1);
                                end
                            end
                            SQ_L2_WAIT: begin
                                if (cur_q.cnt == '0) begin
                                    nxt_d.st   = SQ_ON;
                                    nxt_d.ldo2 = ldo2_want_i;
                                end else begin
                                    nxt_d.cnt = cur_q.cnt - 1'b1;
                                end
                            end
                            default: nxt_d.ldo2 = ldo2_want_i;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: SQ_OFF, cnt: '0, buck: 1'b0, ldo1: 1'b0, ldo2: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign buck_o = cur_q.buck;
    assign ldo1_o = cur_q.ldo1;
    assign ldo2_o = cur_q.ldo2;

    AST_LDO1_UNDER_BUCK: assert property (@(posedge clk) disable iff (!rst_n)
        ldo1_o |-> buck_o); // R4
    AST_LDO2_UNDER_BUCK: assert property (@(posedge clk) disable iff (!rst_n)
        ldo2_o |-> buck_o); // R6
    AST_LDO2_RISES_AFTER_LDO1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo2_o) |-> ldo1_o); // R5
    AST_UV_CUTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok_i |=> (!buck_o && !ldo1_o && !ldo2_o)); // R2
    AST_BUCK_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buck_o) |-> (!ldo1_o && !ldo2_o)); // R6
    AST_BUCK_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buck_o) |-> ($past(on_req_i) && $past(uv_ok_i))); // R2
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int unsigned HF_WIN       = 327_500_000,
    parameter int unsigned LDO1_DLY     = 17_500,
    parameter int unsigned LDO2_DLY     = 12_500,
    parameter int unsigned BUCK_OFF_DLY = 12_500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en_i,
    input  logic hf_trig_i,
    input  logic ldo2_off_i,
    input  logic uv_ok_i,
    input  logic ldo1_pg_i,
    output logic buck_en_o,
    output logic ldo1_en_o,
    output logic ldo2_en_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, synced;
    logic pwr_en_s, hf_s, ldo2_off_s;
    logic win_open, on_req;

    assign raw_in = {pwr_en_i, hf_trig_i, ldo2_off_i};
    assign {pwr_en_s, hf_s, ldo2_off_s} = synced;

    pwr_sync #(.W(NSYNC), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(synced)
    );

    pwr_hf_window #(.HF_WIN(HF_WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .hf_s_i(hf_s), .pwr_en_s_i(pwr_en_s),
        .win_open_o(win_open)
    );

    assign on_req = pwr_en_s || win_open;

    pwr_rail_fsm #(
        .LDO1_DLY(LDO1_DLY), .LDO2_DLY(LDO2_DLY), .BUCK_OFF_DLY(BUCK_OFF_DLY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .on_req_i(on_req), .uv_ok_i(uv_ok_i),
        .ldo1_pg_i(ldo1_pg_i), .ldo2_want_i(!ldo2_off_s),
        .buck_o(buck_en_o), .ldo1_o(ldo1_en_o), .ldo2_o(ldo2_en_o)
    );

    AST_LDO2_OBEYS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo2_en_o) |-> !$past(ldo2_off_s)); // R5
    AST_OFF_WITHOUT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_req && !buck_en_o) |=> !buck_en_o); // R2
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
    localparam int unsigned WIN  = 300;
    localparam int unsigned D1   = 10;
    localparam int unsigned D2   = 8;
    localparam int unsigned DOFF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0, hf = 1'b0, l2_off = 1'b1, uv_ok = 1'b0, pg = 1'b0;
    logic buck, ldo1, ldo2;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.HF_WIN(WIN), .LDO1_DLY(D1), .LDO2_DLY(D2), .BUCK_OFF_DLY(DOFF))
    u_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_en_i(pwr_en), .hf_trig_i(hf),
        .ldo2_off_i(l2_off), .uv_ok_i(uv_ok), .ldo1_pg_i(pg),
        .buck_en_o(buck), .ldo1_en_o(ldo1), .ldo2_en_o(ldo2)
    );

    typedef struct {
        int unsigned at;
        logic [2:0]  exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int unsigned cyc = 0;
    int n_chk = 0, n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: one ns after each rising edge, compare due items
    always @(posedge clk) begin
        #1;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.at != cyc || {buck, ldo1, ldo2} != it.exp) begin
                n_fail++;
                $display("FAIL %s: cycle %0d got buck/ldo1/ldo2=%b expected %b",
                         it.tag, it.at, {buck, ldo1, ldo2}, it.exp);
            end
        end
    end

    task automatic expect_at(int unsigned d, logic [2:0] e, string tag);
        item_t it;
        it.at = cyc + d; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_all();
        // R1: reset state
        tick(3);
        expect_at(1, 3'b000, "R1 during reset");
        tick(2);
        rst_n = 1'b1;
        expect_at(1, 3'b000, "R1 after release");
        tick(3);

        // R2: request present but uv_ok low
        l2_off = 1'b0;
        pwr_en = 1'b1;
        expect_at(5, 3'b000, "R2 gated by uv");
        expect_at(20, 3'b000, "R2 still gated");
        tick(22);
        uv_ok = 1'b1;
        expect_at(1, 3'b100, "R2 buck on uv rise");
        // R4: ldo1 after D1 edges
        expect_at(D1, 3'b100, "R4 ldo1 not early");
        expect_at(D1 + 1, 3'b110, "R4 ldo1 on");
        // R5: waits for power-good
        expect_at(30, 3'b110, "R5 waits for pg");
        tick(31);
        pg = 1'b1;
        expect_at(D2, 3'b110, "R5 ldo2 not early");
        expect_at(D2 + 1, 3'b111, "R5 ldo2 on");
        tick(D2 + 5);

        // R5: ldo2 follows its active-low request
        l2_off = 1'b1;
        expect_at(2, 3'b111, "R5 off latency");
        expect_at(3, 3'b110, "R5 ldo2 off");
        tick(6);
        l2_off = 1'b0;
        expect_at(2, 3'b110, "R5 on latency");
        expect_at(3, 3'b111, "R5 ldo2 back on");
        tick(6);

        // R9: hands-free edge ignored while enabled
        hf = 1'b1;
        tick(4);
        hf = 1'b0;
        tick(4);
        // R6: shutdown order
        pwr_en = 1'b0;
        expect_at(2, 3'b111, "R6 before drop");
        expect_at(3, 3'b101, "R6 ldo1 first");
        expect_at(4, 3'b100, "R6 ldo2 second");
        expect_at(3 + DOFF - 1, 3'b100, "R6 buck not early");
        expect_at(3 + DOFF, 3'b000, "R6 buck last");
        expect_at(3 + DOFF + 60, 3'b000, "R9 no window opened");
        tick(3 + DOFF + 62);

        // R3: power-enable latency from off
        pwr_en = 1'b1;
        expect_at(2, 3'b000, "R3 not early");
        expect_at(3, 3'b100, "R3 buck on");
        expect_at(3 + D1, 3'b110, "R4 ldo1 on");
        expect_at(4 + D1 + D2 - 1, 3'b110, "R5 ldo2 not early");
        expect_at(4 + D1 + D2, 3'b111, "R5 ldo2 on");
        tick(4 + D1 + D2 + 4);
        // R2: loss of uv_ok cuts everything at once
        uv_ok = 1'b0;
        expect_at(1, 3'b000, "R2 uv loss");
        tick(3);
        pwr_en = 1'b0;
        tick(4);
        uv_ok = 1'b1;
        expect_at(10, 3'b000, "R2 stays off");
        tick(12);

        // R7/R8: hands-free window, held high
        hf = 1'b1;
        expect_at(3, 3'b000, "R7 not early");
        expect_at(4, 3'b100, "R7 buck on");
        expect_at(4 + D1, 3'b110, "R7 ldo1 on");
        expect_at(5 + D1 + D2, 3'b111, "R7 ldo2 on");
        expect_at(3 + WIN, 3'b111, "R7 window still open");
        expect_at(4 + WIN, 3'b101, "R7 window closed");
        expect_at(5 + WIN, 3'b100, "R7 ldo2 off");
        expect_at(4 + WIN + DOFF, 3'b000, "R7 buck off");
        expect_at(4 + WIN + DOFF + 100, 3'b000, "R8 held high no retrigger");
        tick(4 + WIN + DOFF + 102);

        // R10: window latched by power-enable
        hf = 1'b0;
        tick(5);
        hf = 1'b1;
        expect_at(4, 3'b100, "R10 window start");
        tick(50);
        pwr_en = 1'b1;
        expect_at(WIN + 30, 3'b111, "R10 held past window");
        tick(WIN + 32);
        pwr_en = 1'b0;
        hf = 1'b0;
        expect_at(3, 3'b101, "R6 ldo1 first again");
        expect_at(3 + DOFF, 3'b000, "R6 buck last again");
        tick(3 + DOFF + 5);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
        end
        tick(2);
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            n_fail++;
            $display("FAIL %s: never compared, got nothing expected %b", it.tag, it.exp);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule